// File: doc/BRIEF.md
# Video Lock Status Hysteresis Filter

This block takes a raw lock indication once per video line and turns it into a steady lock status. A video timing recovery front end reports, on each line strobe, whether its horizontal loop is locked and whether its colour subcarrier loop is locked. The block combines these two bits into one per-line lock condition. It then counts how many consecutive lines disagree with the status it currently reports. The reported status changes only after that count reaches a programmable number of lines.

The thresholds for gaining lock and for losing lock are set separately. Each is chosen by a 3-bit code from a fixed, nonlinear table that spans 1 to 100000 lines. A select input can bypass the filter, so that the status follows the per-line condition directly. A sticky flag records every fall of the reported status and stays set until it is cleared by a pulse.

Top module: `vlk_lock_filter`

## Requirements
- R1: With the filter active and the status unlocked, the status becomes locked on the clock edge that samples the N-th consecutive strobe with the lock condition true. N is chosen by `enter_code` as follows: 0→1, 1→2, 2→5, 3→10, 4→100, 5→500, 6→1000, 7→100000 lines.
- R2: With the filter active and the status locked, the status becomes unlocked after N consecutive strobes with the lock condition false. N is chosen by `exit_code` from the same code-to-lines table as R1.
- R3: When `raw_sel` is 1, `lock_status` shows the lock condition sampled at the most recent strobe, updated on the edge of that strobe. When `raw_sel` is 0, it shows the filtered state.
- R4: When `sc_en` is 0, the lock condition is `hlock` alone and `sclock` has no effect. When `sc_en` is 1, the condition is `hlock` AND `sclock`.
- R5: The entry and exit thresholds are applied independently. The entry count uses only `enter_code` and the exit count uses only `exit_code`.
- R6: A strobed line whose condition matches the current filtered state restarts the consecutive count from zero.
- R7: While `rst_n` is low, and right after it is released, `lock_status` is 0 and `lost_flag` is 0. The consecutive count is also cleared.
- R8: `lost_flag` goes to 1 one cycle after `lock_status` falls from 1 to 0, and then holds. A one-cycle `lost_clr` pulse clears it, but a new fall in the same cycle takes priority over the clear.
- R9: Lines are evaluated only in cycles with `line_stb` high. Without a strobe, changes on `hlock` or `sclock` leave the status and the count unchanged.
- R10: A threshold code that changes while a count is in progress applies at the next strobe comparison. The count already accumulated is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle pulse, once per video line |
| hlock | input | 1 | Raw horizontal lock bit |
| sclock | input | 1 | Raw subcarrier lock bit |
| enter_code | input | 3 | Lines-to-lock code |
| exit_code | input | 3 | Lines-to-unlock code |
| raw_sel | input | 1 | 1: report the per-line condition directly |
| sc_en | input | 1 | 1: subcarrier lock also required |
| lost_clr | input | 1 | Clears the sticky lost-lock flag |
| lock_status | output | 1 | Reported lock status |
| lost_flag | output | 1 | Sticky lost-lock flag |

## Verification
A wrong consecutive count moves the change of `lock_status` earlier or later than the selected threshold. Because of this, the bench drives exact strobe counts for every table code and compares the output on each cycle, so a single-line error shows up at the edge where the change was due. A count that fails to restart shows up as an early lock after an interrupted run of lines. A bad flag priority shows up one cycle after a fall that coincides with a clear.

// File: rtl/vlk_pkg.sv
package vlk_pkg;
   localparam int unsigned CODE_W   = 3;
   localparam int unsigned MAX_LINES = 100000;

   function automatic int unsigned code_lines(input logic [CODE_W-1:0] code);
      int unsigned n;
      unique case (code)
         3'd0: n = 1;
         3'd1: n = 2;
         3'd2: n = 5;
         3'd3: n = 10;
         3'd4: n = 100;
         3'd5: n = 500;
         3'd6: n = 1000;
         default: n = MAX_LINES;
      endcase
      return n;
   endfunction
endpackage

// File: rtl/vlk_line_cond.sv
module vlk_line_cond (
   input  logic hlock_i,
   input  logic sclock_i,
   input  logic sc_en_i,
   output logic cond_o
);
   always_comb begin
      if (sc_en_i) cond_o = hlock_i & sclock_i;
      else         cond_o = hlock_i;
   end
endmodule

// File: rtl/vlk_thresh_sel.sv
module vlk_thresh_sel
   import vlk_pkg::*;
#(
   parameter int unsigned CNT_W = 17
) (
   input  logic [CODE_W-1:0] enter_code_i,
   input  logic [CODE_W-1:0] exit_code_i,
   output logic [CNT_W-1:0]  th_enter_o,
   output logic [CNT_W-1:0]  th_exit_o
);
   localparam int unsigned CAP = (1 << CNT_W) - 1;

   generate
      if (CNT_W < 17) begin : g_bad_width
         $error("vlk_thresh_sel: CNT_W too narrow for largest line count");
      end
   endgenerate

   always_comb begin
      th_enter_o = CNT_W'(code_lines(enter_code_i));
      th_exit_o  = CNT_W'(code_lines(exit_code_i));
   end
endmodule

// File: rtl/vlk_hyst_core.sv
module vlk_hyst_core #(
   parameter int unsigned CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb_i,
   input  logic             cond_i,
   input  logic [CNT_W-1:0] th_enter_i,
   input  logic [CNT_W-1:0] th_exit_i,
   output logic             filt_o,
   output logic             raw_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             filt_q;
   logic             raw_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] th_now;
   logic             reach;

   always_comb begin
      cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      th_now  = filt_q ? th_exit_i : th_enter_i;
      reach   = (cnt_inc >= th_now);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         filt_q <= 1'b0;
         raw_q  <= 1'b0;
         cnt_q  <= '0;
      end else if (stb_i) begin
         raw_q <= cond_i;
         if (cond_i == filt_q) begin
            cnt_q <= '0;
         end else if (reach) begin
            filt_q <= ~filt_q;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_inc;
         end
      end
   end

   assign filt_o = filt_q;
   assign raw_o  = raw_q;

   p_hold_no_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_i |=> ($stable(filt_q) && $stable(cnt_q)));
   p_cnt_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_i && (cond_i == filt_q)) |=> (cnt_q == '0));
   p_single_line_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_i && cond_i && !filt_q && th_enter_i == CNT_W'(1)) |=> filt_q);
   p_single_line_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_i && !cond_i && filt_q && th_exit_i == CNT_W'(1)) |=> !filt_q);
endmodule

// File: rtl/vlk_sticky.sv
module vlk_sticky #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic status_i,
   input  logic clr_i,
   output logic flag_o
);
   logic prev_q;
   logic flag_q;
   logic fall;

   assign fall = prev_q & ~status_i;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= status_i;
   end

   generate
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk) begin
            if (!rst_n)     flag_q <= 1'b0;
            else if (fall)  flag_q <= 1'b1;
            else if (clr_i) flag_q <= 1'b0;
         end
      end else begin : g_clr_first
         always_ff @(posedge clk) begin
            if (!rst_n)     flag_q <= 1'b0;
            else if (clr_i) flag_q <= 1'b0;
            else if (fall)  flag_q <= 1'b1;
         end
      end
   endgenerate

   assign flag_o = flag_q;

   p_flag_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_i) |=> flag_o);
   p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/vlk_lock_filter.sv
module vlk_lock_filter
   import vlk_pkg::*;
#(
   parameter int unsigned CNT_W    = 17,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_stb,
   input  logic              hlock,
   input  logic              sclock,
   input  logic [CODE_W-1:0] enter_code,
   input  logic [CODE_W-1:0] exit_code,
   input  logic              raw_sel,
   input  logic              sc_en,
   input  logic              lost_clr,
   output logic              lock_status,
   output logic              lost_flag
);
   logic             cond;
   logic             filt;
   logic             raw;
   logic [CNT_W-1:0] th_enter;
   logic [CNT_W-1:0] th_exit;

   vlk_line_cond u_cond (
      .hlock_i (hlock),
      .sclock_i(sclock),
      .sc_en_i (sc_en),
      .cond_o  (cond)
   );

   vlk_thresh_sel #(.CNT_W(CNT_W)) u_thr (
      .enter_code_i(enter_code),
      .exit_code_i (exit_code),
      .th_enter_o  (th_enter),
      .th_exit_o   (th_exit)
   );

   vlk_hyst_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb_i     (line_stb),
      .cond_i    (cond),
      .th_enter_i(th_enter),
      .th_exit_i (th_exit),
      .filt_o    (filt),
      .raw_o     (raw)
   );

   assign lock_status = raw_sel ? raw : filt;

   vlk_sticky #(.SET_WINS(SET_WINS)) u_sticky (
      .clk     (clk),
      .rst_n   (rst_n),
      .status_i(lock_status),
      .clr_i   (lost_clr),
      .flag_o  (lost_flag)
   );

   p_raw_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_sel && line_stb) |=> (!raw_sel || lock_status == $past(cond)));
   p_sc_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sc_en && line_stb) |=> (raw == $past(hlock)));
endmodule

// File: tb/tb_vlk_lock_filter.sv
module tb_vlk_lock_filter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_stb = 1'b0, hlock = 1'b0, sclock = 1'b0;
   logic [2:0] enter_code = 3'd0, exit_code = 3'd0;
   logic       raw_sel = 1'b0, sc_en = 1'b0, lost_clr = 1'b0;
   logic       lock_status, lost_flag;

   int compared = 0;
   int mismatched = 0;
   string cur_req = "R7";

   // configuration applied at the next step
   logic [2:0] t_enter = 3'd0, t_exit = 3'd0;
   logic       t_raw = 1'b0, t_sc = 1'b0;

   // reference model
   bit m_filt = 0, m_raw = 0, m_prev = 0, m_flag = 0;
   int unsigned m_cnt = 0;

   logic [1:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   vlk_lock_filter dut (
      .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .hlock(hlock), .sclock(sclock),
      .enter_code(enter_code), .exit_code(exit_code), .raw_sel(raw_sel), .sc_en(sc_en),
      .lost_clr(lost_clr), .lock_status(lock_status), .lost_flag(lost_flag)
   );

   function automatic int unsigned lines_of(input logic [2:0] c);
      int unsigned tbl[8] = '{1, 2, 5, 10, 100, 500, 1000, 100000};
      return tbl[c];
   endfunction

   task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: status/flag actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input bit stb, input bit h, input bit s, input bit clr = 0);
      bit cond, rep_now;
      int unsigned nxt, th;
      @(negedge clk);
      line_stb = stb; hlock = h; sclock = s; lost_clr = clr;
      enter_code = t_enter; exit_code = t_exit; raw_sel = t_raw; sc_en = t_sc;
      cond = h & (t_sc ? s : 1'b1);
      rep_now = t_raw ? m_raw : m_filt;
      if (m_prev && !rep_now) m_flag = 1;
      else if (clr) m_flag = 0;
      m_prev = rep_now;
      if (stb) begin
         m_raw = cond;
         if (cond == m_filt) m_cnt = 0;
         else begin
            nxt = m_cnt + 1;
            th = m_filt ? lines_of(t_exit) : lines_of(t_enter);
            if (nxt >= th) begin m_filt = !m_filt; m_cnt = 0; end
            else m_cnt = nxt;
         end
      end
      exp_q.push_back({t_raw ? m_raw : m_filt, m_flag});
      tag_q.push_back(cur_req);
   endtask

   task automatic lines(input int n, input bit h, input bit s = 1);
      for (int i = 0; i < n; i++) step(1, h, s);
   endtask

   // monitor: compares every cycle after the edge has settled
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            logic [1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {lock_status, lost_flag}, e);
         end
      end
   end

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      // R7: reset state
      repeat (3) @(negedge clk);
      check("R7", {lock_status, lost_flag}, 2'b00);
      rst_n = 1'b1;
      step(0, 0, 0);

      // R1: single-line entry, R2: single-line exit, R8 flag set
      cur_req = "R1"; t_enter = 3'd0; t_exit = 3'd0;
      lines(1, 1);
      cur_req = "R2"; lines(1, 0);
      cur_req = "R8"; step(0, 0, 0); step(0, 0, 0);
      step(0, 0, 0, 1);           // clear
      step(0, 0, 0);

      // R1: sweep entry codes; R2: sweep exit codes
      for (int c = 1; c < 7; c++) begin
         cur_req = "R1"; t_enter = 3'(c); t_exit = 3'(c);
         lines(int'(lines_of(3'(c))), 1);
         cur_req = "R2"; lines(int'(lines_of(3'(c))), 0);
         step(0, 0, 0, 1);
      end

      // R6: interrupted run restarts count (entry 10)
      cur_req = "R6"; t_enter = 3'd3; t_exit = 3'd0;
      lines(9, 1); lines(1, 0); lines(9, 1); lines(1, 1);
      lines(1, 0); step(0, 0, 0, 1);

      // R5: different entry (5) and exit (100) thresholds
      cur_req = "R5"; t_enter = 3'd2; t_exit = 3'd4;
      lines(5, 1); lines(99, 0); lines(1, 1); lines(100, 0);

      // R4: subcarrier enable
      cur_req = "R4"; t_enter = 3'd0; t_exit = 3'd0; t_sc = 1;
      lines(3, 1, 0); lines(1, 1, 1); lines(1, 0, 1);
      t_sc = 0; lines(2, 1, 0); lines(1, 0, 0);
      step(0, 0, 0, 1);

      // R9: no strobe, no change
      cur_req = "R9";
      for (int i = 0; i < 6; i++) step(0, 1, 1);
      t_enter = 3'd1; lines(1, 1);
      for (int i = 0; i < 6; i++) step(0, 0, 0);
      lines(1, 1);

      // R3: raw bypass line by line, then back to filtered
      cur_req = "R3"; t_raw = 1; t_exit = 3'd3;
      lines(1, 0); lines(1, 1); step(0, 0, 0); lines(1, 0); lines(1, 1);
      t_raw = 0; step(0, 1, 1); lines(2, 1);
      step(0, 1, 1, 1);

      // R10: exit code shrinks mid-count, count kept
      cur_req = "R10"; t_exit = 3'd4;
      lines(50, 0);
      t_exit = 3'd3; lines(1, 0);
      step(0, 0, 0);

      // R8: fall and clear in same cycle -> set wins
      cur_req = "R8"; t_enter = 3'd0; t_exit = 3'd0;
      lines(1, 1); step(1, 0, 0, 1); step(0, 0, 0, 1); step(0, 0, 0);

      // R2: largest exit threshold 100000
      cur_req = "R2"; t_exit = 3'd7;
      lines(1, 1); lines(99999, 0); lines(1, 0); step(0, 0, 0);

      repeat (4) @(posedge clk);
      #3;
      finish_run();
   end
endmodule